// File: doc/BRIEF.md
# MII receive qualifier for 10 and 100 Mbit/s

This block sits at the receive side of one repeater port, directly behind a PHY that speaks the media-independent interface. Every rising edge of the receive clock it samples the data lines, data valid and carrier sense. It then emits a clean stream of accepted nibbles together with a valid strobe, a start-of-frame marker and an end-of-frame marker. At 100 Mbit/s the PHY delivers a whole nibble per clock, framed by data valid. At 10 Mbit/s only the lowest data line carries a serial bit, and the block packs four accepted bits into one nibble, least significant bit first.

In serial mode a static configuration input sets the data envelope. Either carrier sense alone qualifies the bits, or carrier sense and data valid must both be high. A rate input selects the speed. Both inputs are treated as static while the port is running and are changed only under reset. If the envelope closes while a serial nibble is only partly built, the partial bits are dropped and a dribble flag rides on the end-of-frame pulse. All outputs are registered and appear one clock after the edge that sampled the inputs which caused them.

Top module: `mii_rx_qualifier`

## Requirements
- R1: While `rst` is high at a rising clock edge, all outputs are low after that edge, and any partly built serial nibble and its bit count are cleared. After reset the next frame assembles from its first bit.
- R2: With `rate_sel`=1, every edge that samples `rx_dv`=1 yields `nib_vld`=1 in the following cycle, with `nib_data` equal to the sampled `rxd`. `crs` has no effect on this.
- R3: With `rate_sel`=1, an edge that samples `rx_dv`=0 yields `nib_vld`=0 in the following cycle, whatever the level of `crs`.
- R4: With `rate_sel`=0, only `rxd[0]` is used as serial data. The levels on `rxd[3:1]` never change `nib_data`.
- R5: With `rate_sel`=0 and `dv_gate_en`=1, a bit is accepted only on an edge where both `rx_dv` and `crs` are high. With `crs` high and `rx_dv` low, no nibble is produced.
- R6: With `rate_sel`=0 and `dv_gate_en`=0, a bit is accepted on every edge where `crs` is high, and `rx_dv` is ignored.
- R7: With `rate_sel`=0, four consecutive accepted bits form one nibble. The first bit lands in `nib_data[0]` and the fourth in `nib_data[3]`. `nib_vld` pulses for one cycle after the edge that accepted the fourth bit, so two serial nibbles are never on adjacent cycles.
- R8: `frm_sof` is high together with `nib_vld` for the first nibble produced after the qualifier rises, and it is low for every later nibble of the same frame.
- R9: `frm_eof` pulses for exactly one cycle after the first edge at which the qualifier is low after having been high. `nib_vld` is low in that cycle.
- R10: When the qualifier falls in 10 Mbit/s mode with one to three bits of a nibble accepted, those bits are discarded and `frm_dribble` is high together with `frm_eof`. In every other case `frm_dribble` stays low, including in 100 Mbit/s mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rx_clk | input | 1 | Receive clock from the PHY; all sampling on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 1 | 1 selects 100 Mbit/s nibble mode, 0 selects 10 Mbit/s serial mode |
| dv_gate_en | input | 1 | Serial mode only: 1 requires data valid and carrier sense, 0 requires carrier sense alone |
| rx_dv | input | 1 | Receive data valid from the PHY |
| crs | input | 1 | Carrier sense from the PHY |
| rxd | input | 4 | Receive data; only bit 0 is used in serial mode |
| nib_vld | output | 1 | Accepted nibble present on `nib_data` this cycle |
| nib_data | output | 4 | Accepted nibble, bit 0 least significant |
| frm_sof | output | 1 | Marks the first nibble of a frame |
| frm_eof | output | 1 | One-cycle pulse after the qualifier falls |
| frm_dribble | output | 1 | Frame ended with a partial serial nibble discarded |

## Verification
The end-of-frame pulse and the dribble flag are meant to appear in the same cycle. The bench provokes this by closing carrier sense after five or six serial bits, and also after only two bits of a frame that never produced a nibble. It judges that both flags are high together, that `nib_vld` is low and that no start marker appeared. A second coincidence is start marker with valid. This is checked at the first 100 Mbit/s nibble, where it follows the sampling edge by one cycle, and at the fourth serial bit, where the rise of the qualifier lies three edges earlier. A one-cycle gap between two 100 Mbit/s frames puts the end pulse and the next start marker on neighbouring cycles, and both are checked.

// File: rtl/mii_rxq_pkg.sv
package mii_rxq_pkg;

  localparam int unsigned MII_W = 4;

  typedef enum logic {
    RATE_10  = 1'b0,
    RATE_100 = 1'b1
  } rate_e;

endpackage

// File: rtl/rxq_gate.sv
module rxq_gate
  import mii_rxq_pkg::*;
(
  input  rate_e rate,
  input  logic  dv_need,
  input  logic  rx_dv,
  input  logic  crs,
  output logic  qual
);

  always_comb begin
    if (rate == RATE_100) begin
      qual = rx_dv;
    end else if (dv_need) begin
      qual = rx_dv & crs;
    end else begin
      qual = crs;
    end
  end

endmodule

// File: rtl/rxq_packer.sv
module rxq_packer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         take,
  input  logic         bit_in,
  output logic         done,
  output logic [W-1:0] word,
  output logic         part
);

  localparam int unsigned CW   = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt;
  logic [W-1:0]  shreg;

  assign done = take && (cnt == LAST);
  assign part = (cnt != '0);

  for (genvar i = 0; i < W; i++) begin : g_word
    if (i == W - 1) begin : g_top
      assign word[i] = bit_in;
    end else begin : g_low
      assign word[i] = shreg[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt   <= '0;
      shreg <= '0;
    end else if (take) begin
      if (done) begin
        cnt   <= '0;
        shreg <= '0;
      end else begin
        cnt        <= cnt + 1'b1;
        shreg[cnt] <= bit_in;
      end
    end else begin
      cnt   <= '0;
      shreg <= '0;
    end
  end

  assert_pack_spacing_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/rxq_framer.sv
module rxq_framer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         qual,
  input  logic         cand_vld,
  input  logic [W-1:0] cand_data,
  input  logic         partial,
  output logic         nib_vld,
  output logic [W-1:0] nib_data,
  output logic         frm_sof,
  output logic         frm_eof,
  output logic         frm_dribble
);

  logic in_frm;
  logic sof_pend;
  logic closing;

  assign closing = in_frm && !qual;

  always_ff @(posedge clk) begin
    if (rst) begin
      nib_vld     <= 1'b0;
      nib_data    <= '0;
      frm_sof     <= 1'b0;
      frm_eof     <= 1'b0;
      frm_dribble <= 1'b0;
      in_frm      <= 1'b0;
      sof_pend    <= 1'b0;
    end else begin
      nib_vld     <= cand_vld;
      if (cand_vld) begin
        nib_data <= cand_data;
      end
      frm_sof     <= cand_vld && (sof_pend || !in_frm);
      frm_eof     <= closing;
      frm_dribble <= closing && partial;
      in_frm      <= qual;
      if (!qual || cand_vld) begin
        sof_pend <= 1'b0;
      end else if (!in_frm) begin
        sof_pend <= 1'b1;
      end
    end
  end

  assert_sof_has_valid_R8: assert property (@(posedge clk) disable iff (rst)
    frm_sof |-> nib_vld);

  assert_eof_no_valid_R9: assert property (@(posedge clk) disable iff (rst)
    frm_eof |-> !nib_vld);

  assert_eof_single_R9: assert property (@(posedge clk) disable iff (rst)
    frm_eof |=> !frm_eof);

  assert_dribble_on_eof_R10: assert property (@(posedge clk) disable iff (rst)
    frm_dribble |-> frm_eof);

endmodule

// File: rtl/mii_rx_qualifier.sv
module mii_rx_qualifier
  import mii_rxq_pkg::*;
#(
  parameter int unsigned W = MII_W
) (
  input  logic         rx_clk,
  input  logic         rst,
  input  logic         rate_sel,
  input  logic         dv_gate_en,
  input  logic         rx_dv,
  input  logic         crs,
  input  logic [W-1:0] rxd,
  output logic         nib_vld,
  output logic [W-1:0] nib_data,
  output logic         frm_sof,
  output logic         frm_eof,
  output logic         frm_dribble
);

  rate_e        rate;
  logic         qual;
  logic         serial;
  logic         pk_done;
  logic [W-1:0] pk_word;
  logic         pk_part;
  logic         cand_vld;
  logic [W-1:0] cand_data;

  assign rate   = rate_e'(rate_sel);
  assign serial = (rate == RATE_10);

  rxq_gate u_gate (
    .rate    (rate),
    .dv_need (dv_gate_en),
    .rx_dv   (rx_dv),
    .crs     (crs),
    .qual    (qual)
  );

  rxq_packer #(.W(W)) u_pack (
    .clk    (rx_clk),
    .rst    (rst),
    .en     (serial),
    .take   (qual && serial),
    .bit_in (rxd[0]),
    .done   (pk_done),
    .word   (pk_word),
    .part   (pk_part)
  );

  always_comb begin
    if (serial) begin
      cand_vld  = pk_done;
      cand_data = pk_word;
    end else begin
      cand_vld  = qual;
      cand_data = rxd;
    end
  end

  rxq_framer #(.W(W)) u_frame (
    .clk         (rx_clk),
    .rst         (rst),
    .qual        (qual),
    .cand_vld    (cand_vld),
    .cand_data   (cand_data),
    .partial     (pk_part && serial),
    .nib_vld     (nib_vld),
    .nib_data    (nib_data),
    .frm_sof     (frm_sof),
    .frm_eof     (frm_eof),
    .frm_dribble (frm_dribble)
  );

  assert_fast_nibble_R2: assert property (@(posedge rx_clk) disable iff (rst)
    (!$past(rst) && $past(rate_sel) && $past(rx_dv)) |-> (nib_vld && nib_data == $past(rxd)));

  assert_dribble_serial_R10: assert property (@(posedge rx_clk) disable iff (rst)
    (!$past(rst) && frm_dribble) |-> !$past(rate_sel));

endmodule

// File: tb/sim_mii_rx_qualifier.sv
module sim_mii_rx_qualifier;

  localparam int CLK_PERIOD = 10;

  logic       rx_clk = 1'b0;
  logic       rst = 1'b1;
  logic       rate_sel = 1'b0;
  logic       dv_gate_en = 1'b0;
  logic       rx_dv = 1'b0;
  logic       crs = 1'b0;
  logic [3:0] rxd = 4'h0;
  logic       nib_vld;
  logic [3:0] nib_data;
  logic       frm_sof;
  logic       frm_eof;
  logic       frm_dribble;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) rx_clk = ~rx_clk;

  mii_rx_qualifier u0 (
    .rx_clk      (rx_clk),
    .rst         (rst),
    .rate_sel    (rate_sel),
    .dv_gate_en  (dv_gate_en),
    .rx_dv       (rx_dv),
    .crs         (crs),
    .rxd         (rxd),
    .nib_vld     (nib_vld),
    .nib_data    (nib_data),
    .frm_sof     (frm_sof),
    .frm_eof     (frm_eof),
    .frm_dribble (frm_dribble)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic expect_out(input string tag, input logic v, input logic [3:0] d,
                            input logic s, input logic e, input logic dr);
    chk(tag, "nib_vld", int'(nib_vld), int'(v));
    if (v) chk(tag, "nib_data", int'(nib_data), int'(d));
    chk(tag, "frm_sof", int'(frm_sof), int'(s));
    chk(tag, "frm_eof", int'(frm_eof), int'(e));
    chk(tag, "frm_dribble", int'(frm_dribble), int'(dr));
  endtask

  // Inputs change 1 time unit after an edge; outputs are read 1 unit after the next edge.
  task automatic step(input logic dv, input logic cs, input logic [3:0] d);
    rx_dv = dv;
    crs   = cs;
    rxd   = d;
    @(posedge rx_clk);
    #1;
  endtask

  task automatic do_reset(input logic rate, input logic gate);
    rst = 1'b1;
    rate_sel = rate;
    dv_gate_en = gate;
    step(1'b0, 1'b0, 4'h0);
    step(1'b0, 1'b0, 4'h0);
    rst = 1'b0;
    step(1'b0, 1'b0, 4'h0);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    rate_sel = 1'b1;
    step(1'b1, 1'b1, 4'hA);
    step(1'b1, 1'b1, 4'h5);
    expect_out("R1 reset outputs", 1'b0, 4'h0, 1'b0, 1'b0, 1'b0);
    // serial: two bits, reset while carrier stays up, then a fresh frame
    do_reset(1'b0, 1'b0);
    step(1'b0, 1'b1, 4'h1);
    step(1'b0, 1'b1, 4'h1);
    rst = 1'b1;
    step(1'b0, 1'b1, 4'h1);
    expect_out("R1 reset mid nibble", 1'b0, 4'h0, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    step(1'b0, 1'b0, 4'h0);
    step(1'b0, 1'b1, 4'h0);
    step(1'b0, 1'b1, 4'h0);
    expect_out("R1 no stale bits", 1'b0, 4'h0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 4'h0);
    step(1'b0, 1'b1, 4'h1);
    expect_out("R1 fresh nibble", 1'b1, 4'h8, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_fast;
    do_reset(1'b1, 1'b1);
    step(1'b0, 1'b1, 4'h9);
    expect_out("R3 dv low crs high", 1'b0, 4'h0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 4'h3);
    expect_out("R2 R8 first nibble", 1'b1, 4'h3, 1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 4'hA);
    expect_out("R2 R8 second nibble", 1'b1, 4'hA, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 4'h5);
    expect_out("R2 crs ignored", 1'b1, 4'h5, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 4'hF);
    expect_out("R9 R10 fast eof", 1'b0, 4'h0, 1'b0, 1'b1, 1'b0);
    step(1'b1, 1'b1, 4'hC);
    expect_out("R8 back to back sof", 1'b1, 4'hC, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 4'h0);
    expect_out("R9 second eof", 1'b0, 4'h0, 1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 4'h0);
    expect_out("R9 eof one cycle", 1'b0, 4'h0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_serial_loose;
    do_reset(1'b0, 1'b0);
    // R6: rx_dv low throughout; R4: rxd[3:1] held at junk
    step(1'b0, 1'b1, 4'hF);
    expect_out("R7 bit1 pending", 1'b0, 4'h0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 4'hE);
    step(1'b0, 1'b1, 4'hB);
    expect_out("R7 bit3 pending", 1'b0, 4'h0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 4'h7);
    expect_out("R4 R6 R7 R8 nibble D", 1'b1, 4'hD, 1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b1, 4'hE);
    expect_out("R7 no adjacent nibble", 1'b0, 4'h0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 4'h6);
    step(1'b1, 1'b1, 4'hB);
    step(1'b0, 1'b1, 4'hA);
    expect_out("R4 R7 R8 nibble 4", 1'b1, 4'h4, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 4'h1);
    expect_out("R9 R10 serial eof", 1'b0, 4'h0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_serial_strict;
    do_reset(1'b0, 1'b1);
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 1'b1, 4'h1);
    end
    expect_out("R5 crs alone rejected", 1'b0, 4'h0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b1, 4'h0);
    step(1'b1, 1'b1, 4'h1);
    step(1'b1, 1'b1, 4'h1);
    step(1'b1, 1'b1, 4'h0);
    expect_out("R5 R7 R8 nibble 6", 1'b1, 4'h6, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 4'h1);
    expect_out("R5 R9 dv drop ends frame", 1'b0, 4'h0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_dribble;
    do_reset(1'b0, 1'b0);
    step(1'b0, 1'b1, 4'h0);
    step(1'b0, 1'b1, 4'h1);
    step(1'b0, 1'b1, 4'h0);
    step(1'b0, 1'b1, 4'h1);
    expect_out("R7 nibble A", 1'b1, 4'hA, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 4'h1);
    step(1'b0, 1'b1, 4'h1);
    step(1'b0, 1'b0, 4'h1);
    expect_out("R10 dribble with eof", 1'b0, 4'h0, 1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b1, 4'h1);
    step(1'b0, 1'b1, 4'h1);
    step(1'b0, 1'b1, 4'h1);
    step(1'b0, 1'b1, 4'h0);
    expect_out("R10 partial discarded", 1'b1, 4'h7, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 4'h0);
    expect_out("R10 clean eof", 1'b0, 4'h0, 1'b0, 1'b1, 1'b0);
    // frame shorter than a nibble: no start marker, dribble on end
    step(1'b0, 1'b1, 4'h1);
    expect_out("R8 no sof short", 1'b0, 4'h0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 4'h1);
    step(1'b0, 1'b0, 4'h0);
    expect_out("R10 short frame dribble", 1'b0, 4'h0, 1'b0, 1'b1, 1'b1);
  endtask

  initial begin
    t_reset();
    t_fast();
    t_serial_loose();
    t_serial_strict();
    t_dribble();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule